// File: doc/BRIEF.md
# Descriptor Ring Gather Copy Engine

A single copy channel that moves words between locations of a small on-chip data memory under the control of two descriptor rings. Software fills source descriptors with a byte address, a byte count and a flags field. It fills destination descriptors with the byte address of an empty receive buffer and a byte count of zero. It then advances the two write indices. The engine takes source entries strictly in ring order and copies each one into the current destination buffer. A run of source entries flagged as gather is packed back to back into one buffer. The destination descriptor is then completed by writing the total byte count, the transfer metadata and a byte-swap indication into it.

Every access from software goes through a register bus with a valid/ready handshake. A request is accepted on a rising edge where both `req_valid` and `req_ready` are high. Read data appears on `rsp_rdata`, with `rsp_valid` high, one cycle after the read was accepted. Register and descriptor accesses are always ready. Accesses to the data-memory window are held off while the engine is working through a descriptor. The requester must keep its request stable until it is accepted. Copies move whole 32-bit words: an entry of L bytes moves ceil(L/4) words, and every entry in a gather run except the last should have a length that is a multiple of 4.

Top module: `ring_copy_engine`

Address map (word addresses on `req_addr`, default parameters):

- Bit 8 set: data-memory word `req_addr[5:0]`.
- 0x000 control: bits [15:0] hold the per-entry length cap, bit 16 enables source-side swapping and bit 17 enables destination-side swapping. The reset value is 0x0000FFFF.
- 0x001 source write index; 0x002 source read index (read only).
- 0x003 destination write index; 0x004 destination read index (read only).
- 0x005 status: bit 0 is the sticky truncation flag. Writing 1 to bit 0 clears it.
- 0x040 + 2i: the byte address of source descriptor i. 0x041 + 2i: the same descriptor's word {flags[15:0], count[15:0]}.
- 0x080 + 2i and 0x081 + 2i: the same two words for destination descriptor i.
- Flags field: bits [15:4] hold the metadata, bit 3 is gather and bit 2 is byte swap.

## Requirements
- R1: After reset, the control register reads 0x0000FFFF, and the status register and all four ring indices read 0.
- R2: A source entry that does not have the gather bit set is copied as ceil(count/4) words, from its address to the current destination buffer. No word past that count is written. The source and destination read indices each advance by one.
- R3: Consecutive source entries with gather (flags bit 3) set, together with the first following entry that has it clear, are placed back to back in one destination buffer. Exactly one destination descriptor is completed, and its count is the sum of the entries' counts.
- R4: The completed destination descriptor has the following flags. Bits [15:4] hold the metadata of the last entry of the run. Bit 2 is the OR of the entries' swap bits. Bit 3 is 0.
- R5: A copied word is byte-reversed when an odd number of these are set: the entry's swap flag (bit 2), control bit 16 and control bit 17.
- R6: While no destination buffer is posted (the destination read and write indices are equal), a pending source entry is not processed. The source read index stays put and no memory word is written until a buffer is posted.
- R7: A source count larger than the cap in control bits [15:0] is cut to the cap, and status bit 0 is set. Status bit 0 stays set until a 1 is written to it.
- R8: The ring indices wrap modulo the ring size (8 entries by default). Entries on both sides of the wrap point are processed in order.
- R9: Register reads return data one cycle after acceptance with no wait state, even while a copy is running. A data-memory access that is issued during a copy is held with `req_ready` low until the copy ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Bus request can be accepted this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W (9) | Word address of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rsp_rdata | output | 32 | Read data |

## Verification
The assertions assume the following about software behaviour:

- Software never moves a write index backwards.
- Software never posts more than N-1 entries on a ring.
- Software does not rewrite a descriptor the engine still owns.

Under these conditions, read indices move by at most one step per cycle, never move off an empty ring, and the truncation flag clears only on request. The directed stimulus always waits for the read indices to reach their expected values before it reuses a descriptor slot. It advances each write index only forward, by at most two entries at a time, and it reposts each destination descriptor with a count of zero before handing the buffer over.

// File: rtl/ce_pkg.sv
`timescale 1ns/1ps
package ce_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ENTRY, ST_COPY, ST_FINISH} ce_state_e;

  function automatic logic [31:0] ce_bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/ce_ring_ptr.sv
`timescale 1ns/1ps
module ce_ring_ptr #(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [IW-1:0] wr_idx,
  output logic [IW-1:0] rd_idx,
  output logic          avail
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_idx <= '0;
    else if (adv) rd_idx <= rd_idx + 1'b1;
  end
  assign avail = (rd_idx != wr_idx);
endmodule

// File: rtl/ce_mover.sv
`timescale 1ns/1ps
module ce_mover
  import ce_pkg::*;
#(
  parameter int MW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   cfg_cap,
  input  logic          cfg_src_sw,
  input  logic          cfg_dst_sw,
  input  logic          src_avail,
  input  logic          dst_avail,
  input  logic [MW-1:0] s_word,
  input  logic [15:0]   s_len,
  input  logic [11:0]   s_meta,
  input  logic          s_gather,
  input  logic          s_swap,
  input  logic [MW-1:0] d_word,
  input  logic [31:0]   mem_rdata,
  output logic [MW-1:0] mem_raddr,
  output logic          mem_we,
  output logic [MW-1:0] mem_waddr,
  output logic [31:0]   mem_wdata,
  output logic          src_adv,
  output logic          dst_adv,
  output logic [31:0]   wb_word,
  output logic          trunc_evt,
  output logic          busy
);
  ce_state_e     state;
  logic [MW-1:0] sptr, dptr;
  logic [13:0]   words;
  logic [15:0]   total;
  logic [11:0]   meta;
  logic          swp_or, gat, ent_swap, in_run;
  logic [15:0]   eff;
  logic [13:0]   eff_words;
  logic [31:0]   w1, w2;

  assign eff       = (s_len > cfg_cap) ? cfg_cap : s_len;
  assign eff_words = eff[15:2] + {13'd0, |eff[1:0]};
  assign trunc_evt = (state == ST_ENTRY) && (s_len > cfg_cap);
  assign busy      = (state != ST_IDLE);

  assign w1        = cfg_src_sw ? ce_bswap(mem_rdata) : mem_rdata;
  assign w2        = ent_swap   ? ce_bswap(w1) : w1;
  assign mem_wdata = cfg_dst_sw ? ce_bswap(w2) : w2;
  assign mem_raddr = sptr;
  assign mem_waddr = dptr;
  assign mem_we    = (state == ST_COPY);
  assign src_adv   = (state == ST_FINISH);
  assign dst_adv   = (state == ST_FINISH) && !gat;
  assign wb_word   = {meta, 1'b0, swp_or, 2'b00, total};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sptr     <= '0;
      dptr     <= '0;
      words    <= '0;
      total    <= '0;
      meta     <= '0;
      swp_or   <= 1'b0;
      gat      <= 1'b0;
      ent_swap <= 1'b0;
      in_run   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (src_avail && (in_run || dst_avail)) begin
            if (!in_run) begin
              dptr   <= d_word;
              total  <= '0;
              swp_or <= 1'b0;
            end
            state <= ST_ENTRY;
          end
        end
        ST_ENTRY: begin
          sptr     <= s_word;
          words    <= eff_words;
          total    <= total + eff;
          meta     <= s_meta;
          gat      <= s_gather;
          ent_swap <= s_swap;
          swp_or   <= swp_or | s_swap;
          state    <= (eff_words == '0) ? ST_FINISH : ST_COPY;
        end
        ST_COPY: begin
          sptr  <= sptr + 1'b1;
          dptr  <= dptr + 1'b1;
          words <= words - 1'b1;
          if (words == 14'd1) state <= ST_FINISH;
        end
        ST_FINISH: begin
          in_run <= gat;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_copy_engine.sv
`timescale 1ns/1ps
module ring_copy_engine #(
  parameter int NENT      = 8,
  parameter int MEM_WORDS = 64,
  parameter int ADDR_W    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata
);
  localparam int IW = $clog2(NENT);
  localparam int MW = $clog2(MEM_WORDS);
  localparam int RW = ADDR_W - 3;

  localparam logic [RW-1:0] A_CTRL = RW'(0);
  localparam logic [RW-1:0] A_SWR  = RW'(1);
  localparam logic [RW-1:0] A_SRD  = RW'(2);
  localparam logic [RW-1:0] A_DWR  = RW'(3);
  localparam logic [RW-1:0] A_DRD  = RW'(4);
  localparam logic [RW-1:0] A_STAT = RW'(5);

  logic [15:0]   cap;
  logic          src_sw_en, dst_sw_en, err;
  logic [IW-1:0] src_wr, dst_wr, src_rd, dst_rd;
  logic          src_avail, dst_avail;
  logic [31:0]   s_addr [NENT];
  logic [31:0]   s_lf   [NENT];
  logic [31:0]   d_addr [NENT];
  logic [31:0]   d_lf   [NENT];
  logic [31:0]   mem    [MEM_WORDS];

  logic          mem_sel, acc, wr, err_clr;
  logic [1:0]    region;
  logic [RW-1:0] roff;
  logic [IW-1:0] didx;
  logic          dhi;

  logic [MW-1:0] m_raddr, m_waddr;
  logic          m_we, src_adv, dst_adv, trunc_evt, busy;
  logic [31:0]   m_wdata, wb_word;

  assign mem_sel   = req_addr[ADDR_W-1];
  assign region    = req_addr[ADDR_W-2:ADDR_W-3];
  assign roff      = req_addr[RW-1:0];
  assign didx      = req_addr[IW:1];
  assign dhi       = req_addr[0];
  assign req_ready = !(mem_sel && busy);
  assign acc       = req_valid && req_ready;
  assign wr        = acc && req_write;
  assign err_clr   = wr && !mem_sel && (region == 2'b00) && (roff == A_STAT) && req_wdata[0];

  ce_ring_ptr #(.IW(IW)) u_src_ptr (
    .clk(clk), .rst_n(rst_n), .adv(src_adv), .wr_idx(src_wr),
    .rd_idx(src_rd), .avail(src_avail)
  );
  ce_ring_ptr #(.IW(IW)) u_dst_ptr (
    .clk(clk), .rst_n(rst_n), .adv(dst_adv), .wr_idx(dst_wr),
    .rd_idx(dst_rd), .avail(dst_avail)
  );

  ce_mover #(.MW(MW)) u_mover (
    .clk(clk), .rst_n(rst_n),
    .cfg_cap(cap), .cfg_src_sw(src_sw_en), .cfg_dst_sw(dst_sw_en),
    .src_avail(src_avail), .dst_avail(dst_avail),
    .s_word(s_addr[src_rd][MW+1:2]), .s_len(s_lf[src_rd][15:0]),
    .s_meta(s_lf[src_rd][31:20]), .s_gather(s_lf[src_rd][19]),
    .s_swap(s_lf[src_rd][18]), .d_word(d_addr[dst_rd][MW+1:2]),
    .mem_rdata(mem[m_raddr]), .mem_raddr(m_raddr), .mem_we(m_we),
    .mem_waddr(m_waddr), .mem_wdata(m_wdata),
    .src_adv(src_adv), .dst_adv(dst_adv), .wb_word(wb_word),
    .trunc_evt(trunc_evt), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap       <= 16'hFFFF;
      src_sw_en <= 1'b0;
      dst_sw_en <= 1'b0;
      src_wr    <= '0;
      dst_wr    <= '0;
      err       <= 1'b0;
    end else begin
      if (wr && !mem_sel && region == 2'b00) begin
        unique case (roff)
          A_CTRL: begin
            cap       <= req_wdata[15:0];
            src_sw_en <= req_wdata[16];
            dst_sw_en <= req_wdata[17];
          end
          A_SWR:  src_wr <= req_wdata[IW-1:0];
          A_DWR:  dst_wr <= req_wdata[IW-1:0];
          default: ;
        endcase
      end
      if (err_clr) err <= 1'b0;
      if (trunc_evt) err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr && mem_sel) mem[req_addr[MW-1:0]] <= req_wdata;
    if (m_we) mem[m_waddr] <= m_wdata;
    if (wr && !mem_sel && region == 2'b01) begin
      if (dhi) s_lf[didx] <= req_wdata;
      else     s_addr[didx] <= req_wdata;
    end
    if (wr && !mem_sel && region == 2'b10) begin
      if (dhi) d_lf[didx] <= req_wdata;
      else     d_addr[didx] <= req_wdata;
    end
    if (dst_adv) d_lf[dst_rd] <= wb_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc && !req_write;
      if (acc && !req_write) begin
        if (mem_sel) rsp_rdata <= mem[req_addr[MW-1:0]];
        else begin
          unique case (region)
            2'b00: begin
              unique case (roff)
                A_CTRL:  rsp_rdata <= {14'd0, dst_sw_en, src_sw_en, cap};
                A_SWR:   rsp_rdata <= 32'(src_wr);
                A_SRD:   rsp_rdata <= 32'(src_rd);
                A_DWR:   rsp_rdata <= 32'(dst_wr);
                A_DRD:   rsp_rdata <= 32'(dst_rd);
                A_STAT:  rsp_rdata <= {31'd0, err};
                default: rsp_rdata <= '0;
              endcase
            end
            2'b01:   rsp_rdata <= dhi ? s_lf[didx] : s_addr[didx];
            2'b10:   rsp_rdata <= dhi ? d_lf[didx] : d_addr[didx];
            default: rsp_rdata <= '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/ce_checker.sv
`timescale 1ns/1ps
module ce_checker #(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [IW-1:0] src_rd,
  input logic [IW-1:0] src_wr,
  input logic [IW-1:0] dst_rd,
  input logic [IW-1:0] dst_wr,
  input logic          err,
  input logic          err_clr
);
  a_r8_src_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (src_rd == $past(src_rd)) || (src_rd == IW'($past(src_rd) + 1'b1)));

  a_r8_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dst_rd == $past(dst_rd)) || (dst_rd == IW'($past(dst_rd) + 1'b1)));

  a_r2_src_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd == src_wr) |=> $stable(src_rd));

  a_r6_dst_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_rd == dst_wr) |=> $stable(dst_rd));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err);
endmodule

bind ring_copy_engine ce_checker #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_rd(src_rd), .src_wr(src_wr),
  .dst_rd(dst_rd), .dst_wr(dst_wr), .err(err), .err_clr(err_clr)
);

// File: tb/sim_ring_copy_engine.sv
`timescale 1ns/1ps
module sim_ring_copy_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [8:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  int          checks = 0, fails = 0, stall_cyc = 0;
  logic [31:0] q;

  localparam logic [8:0] R_CTRL = 9'h000, R_SWR = 9'h001, R_SRD = 9'h002;
  localparam logic [8:0] R_DWR = 9'h003, R_DRD = 9'h004, R_STAT = 9'h005;

  always #2.5 clk = ~clk;

  ring_copy_engine u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  function automatic logic [31:0] pat(input int i);
    return 32'hC0DE_0000 + i * 32'h0001_0301;
  endfunction
  function automatic logic [31:0] sent(input int i);
    return 32'hDEAD_0000 | i;
  endfunction
  function automatic logic [31:0] rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
  function automatic logic [8:0] sd(input int i, input int hi);
    return 9'(9'h040 + 2 * i + hi);
  endfunction
  function automatic logic [8:0] dd(input int i, input int hi);
    return 9'(9'h080 + 2 * i + hi);
  endfunction
  function automatic logic [8:0] mw(input int i);
    return 9'(9'h100 + i);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [8:0] a, input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    stall_cyc = 0;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
      stall_cyc++;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r = rsp_rdata;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    bus(1'b1, a, d, dummy);
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] r);
    bus(1'b0, a, 32'd0, r);
  endtask

  task automatic wait_eq(input string req, input string what, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] r;
    for (int n = 0; n < 400; n++) begin
      rd(a, r);
      if (r == exp) break;
    end
    chk(req, what, r, exp);
  endtask

  task automatic t_reset;
    rd(R_CTRL, q); chk("R1", "control reset", q, 32'h0000_FFFF);
    rd(R_STAT, q); chk("R1", "status reset", q, 32'd0);
    rd(R_SRD, q);  chk("R1", "source read index reset", q, 32'd0);
    rd(R_DRD, q);  chk("R1", "destination read index reset", q, 32'd0);
    rd(R_SWR, q);  chk("R1", "source write index reset", q, 32'd0);
  endtask

  task automatic t_single;
    wr(dd(0, 0), 32'd128); wr(dd(0, 1), 32'd0);
    wr(sd(0, 0), 32'd0);   wr(sd(0, 1), {16'h12A0, 16'd10});
    wr(R_DWR, 32'd1); wr(R_SWR, 32'd1);
    wait_eq("R2", "source read index", R_SRD, 32'd1);
    wait_eq("R2", "destination read index", R_DRD, 32'd1);
    for (int i = 0; i < 3; i++) begin
      rd(mw(32 + i), q); chk("R2", "copied word", q, pat(i));
    end
    rd(mw(35), q); chk("R2", "word past count untouched", q, sent(35));
    rd(dd(0, 1), q); chk("R4", "single completion word", q, {16'h12A0, 16'd10});
  endtask

  task automatic t_gather;
    wr(dd(1, 0), 32'd160); wr(dd(1, 1), 32'd0);
    wr(sd(1, 0), 32'd16);  wr(sd(1, 1), {16'h0018, 16'd8});
    wr(sd(2, 0), 32'd32);  wr(sd(2, 1), {16'h3C54, 16'd4});
    wr(R_DWR, 32'd2); wr(R_SWR, 32'd3);
    wait_eq("R3", "source index after gather run", R_SRD, 32'd3);
    wait_eq("R3", "one destination consumed", R_DRD, 32'd2);
    rd(mw(40), q); chk("R3", "gather word 0", q, pat(4));
    rd(mw(41), q); chk("R3", "gather word 1", q, pat(5));
    rd(mw(42), q); chk("R5", "entry-swapped word", q, rev(pat(8)));
    rd(mw(43), q); chk("R3", "no word past run", q, sent(43));
    rd(dd(1, 1), q); chk("R4", "gather completion word", q, {16'h3C54, 16'd12});
  endtask

  task automatic t_stall;
    wr(dd(2, 0), 32'd192); wr(dd(2, 1), 32'd0);
    wr(sd(3, 0), 32'd0);   wr(sd(3, 1), {16'h0000, 16'd4});
    wr(R_SWR, 32'd4);
    repeat (40) @(negedge clk);
    rd(R_SRD, q); chk("R6", "source index held without buffer", q, 32'd3);
    rd(mw(48), q); chk("R6", "no write without buffer", q, sent(48));
    wr(R_DWR, 32'd3);
    wait_eq("R6", "source index after post", R_SRD, 32'd4);
    rd(mw(48), q); chk("R6", "copy after post", q, pat(0));
  endtask

  task automatic t_trunc;
    wr(R_CTRL, 32'h0000_0004);
    wr(dd(3, 0), 32'd208); wr(dd(3, 1), 32'd0);
    wr(sd(4, 0), 32'd0);   wr(sd(4, 1), {16'h0000, 16'd12});
    wr(R_DWR, 32'd4); wr(R_SWR, 32'd5);
    wait_eq("R7", "destination index", R_DRD, 32'd4);
    rd(mw(52), q); chk("R7", "first word copied", q, pat(0));
    rd(mw(53), q); chk("R7", "word beyond cap untouched", q, sent(53));
    rd(dd(3, 1), q); chk("R7", "truncated count", q, {16'h0000, 16'd4});
    rd(R_STAT, q); chk("R7", "sticky flag set", q, 32'd1);
    wr(R_CTRL, 32'h0000_FFFF);
    rd(R_STAT, q); chk("R7", "flag still set", q, 32'd1);
    wr(R_STAT, 32'd1);
    rd(R_STAT, q); chk("R7", "flag cleared", q, 32'd0);
  endtask

  task automatic t_ring_swap;
    wr(R_CTRL, 32'h0001_FFFF);
    wr(dd(4, 0), 32'd224); wr(dd(4, 1), 32'd0);
    wr(sd(5, 0), 32'd4);   wr(sd(5, 1), {16'h0000, 16'd4});
    wr(R_DWR, 32'd5); wr(R_SWR, 32'd6);
    wait_eq("R5", "destination index", R_DRD, 32'd5);
    rd(mw(56), q); chk("R5", "source-side swap", q, rev(pat(1)));
    wr(R_CTRL, 32'h0003_FFFF);
    wr(dd(5, 0), 32'd228); wr(dd(5, 1), 32'd0);
    wr(sd(6, 0), 32'd8);   wr(sd(6, 1), {16'h0004, 16'd4});
    wr(R_DWR, 32'd6); wr(R_SWR, 32'd7);
    wait_eq("R5", "destination index", R_DRD, 32'd6);
    rd(mw(57), q); chk("R5", "three swaps net one", q, rev(pat(2)));
    rd(dd(5, 1), q); chk("R4", "swap flag carried", q, {16'h0004, 16'd4});
    wr(R_CTRL, 32'h0000_FFFF);
  endtask

  task automatic t_wrap;
    wr(dd(6, 0), 32'd232); wr(dd(6, 1), 32'd0);
    wr(dd(7, 0), 32'd236); wr(dd(7, 1), 32'd0);
    wr(sd(7, 0), 32'd12);  wr(sd(7, 1), {16'h0000, 16'd4});
    wr(sd(0, 0), 32'd24);  wr(sd(0, 1), {16'h0000, 16'd4});
    wr(R_DWR, 32'd0); wr(R_SWR, 32'd1);
    wait_eq("R8", "source index wrapped", R_SRD, 32'd1);
    wait_eq("R8", "destination index wrapped", R_DRD, 32'd0);
    rd(mw(58), q); chk("R8", "entry before wrap", q, pat(3));
    rd(mw(59), q); chk("R8", "entry after wrap", q, pat(6));
  endtask

  task automatic t_busy;
    int reg_stall;
    wr(dd(0, 0), 32'd64); wr(dd(0, 1), 32'd0);
    wr(sd(1, 0), 32'd0);  wr(sd(1, 1), {16'h0000, 16'd40});
    wr(R_DWR, 32'd1); wr(R_SWR, 32'd2);
    rd(R_DWR, q);
    reg_stall = stall_cyc;
    chk("R9", "register read wait states", 32'(reg_stall), 32'd0);
    chk("R9", "register read data", q, 32'd1);
    rd(mw(0), q);
    chk("R9", "memory access held during copy", 32'(stall_cyc > 0), 32'd1);
    wait_eq("R9", "source index after long copy", R_SRD, 32'd2);
    rd(mw(25), q); chk("R2", "last word of long copy", q, pat(9));
    rd(dd(0, 1), q); chk("R2", "long copy count", q, {16'h0000, 16'd40});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    for (int i = 0; i < 64; i++) wr(mw(i), (i < 12) ? pat(i) : sent(i));
    t_single;
    t_gather;
    t_stall;
    t_trunc;
    t_ring_swap;
    t_wrap;
    t_busy;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule